// File: doc/BRIEF.md
# Serial Ethernet Receive Deframer

This block sits behind a 10 Mbit/s media-independent receive interface that delivers one data bit per receive clock, together with a carrier-sense line. On a new carrier it emits a start-of-packet pulse. It then discards a fixed number of leading preamble bits and looks for the start-of-frame delimiter. After the delimiter it packs each group of eight bits into a byte register that the host reads, with a one-clock byte-valid pulse for each byte. When carrier goes away it reports the end of the packet. The host must read each byte within the eight clocks before the next byte replaces it.

In half duplex the block discards a packet whose carrier starts while the local transmitter is active, so the station does not capture its own frames. While a collision is signalled it also ignores carrier drops during a reception, because carrier can glitch during a collision. In full duplex neither filter applies. A 16-bit count of received bytes and a flag for a carrier that ended before any delimiter go to a separate status block. CRC checking and address classification are handled elsewhere.

Top module: `rx_deframer`

## Requirements
- R1: While reset is active, every pulse output, `noDelimiter`, `rxByte` and `byteCount` read zero.
- R2: A rising edge of `carrierSense` while idle gives a one-clock `sopPulse` in the clock after the edge at which carrier is first seen high. A carrier that is already high when reset is released gives no `sopPulse`.
- R3: The bit sampled at the carrier-rise edge and the next 9 bits are discarded. A delimiter pattern that lies wholly or partly inside those 10 bits is not recognised.
- R4: After the discarded bits, the delimiter 1,0,1,0,1,0,1,1 in arrival order (0xD5 when packed least significant bit first) gives a one-clock `sfdPulse` in the clock after its last bit. If the delimiter's first bit is at offset p from the carrier-rise edge, `sfdPulse` follows edge p+7.
- R5: After the delimiter, bits are packed least significant bit first. Each eighth bit loads `rxByte` and gives a one-clock `byteValid` in the next clock. The first byte follows edge p+15.
- R6: `rxByte` changes only in a clock where `byteValid` is high, and it holds its value until the next byte is complete.
- R7: The first edge at which carrier is absent gives a one-clock `eopPulse` in the clock after that edge. Trailing bits that do not fill a byte produce no `byteValid`.
- R8: In half duplex (`fullDuplex` low), a packet whose carrier rises while `txEnable` is high produces no pulses of any kind and leaves `byteCount` and `noDelimiter` unchanged. In full duplex `txEnable` has no effect.
- R9: In half duplex, a low `carrierSense` with `collision` high does not end a reception in progress, and the bits keep being packed. In full duplex `collision` is ignored and the carrier drop ends the packet.
- R10: If carrier ends before a delimiter is found, no `byteValid` is produced, `eopPulse` is still issued, and `noDelimiter` goes high with it and stays high until the next `sopPulse`.
- R11: `byteCount` is cleared with each `sopPulse`, rises by one with each `byteValid`, saturates at its maximum, and holds after the packet ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock; one serial bit per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| carrierSense | input | 1 | Carrier present on the medium |
| rxBit | input | 1 | Serial receive data |
| txEnable | input | 1 | Local transmitter active |
| fullDuplex | input | 1 | High selects full duplex, low selects half duplex |
| collision | input | 1 | Collision indication |
| sopPulse | output | 1 | Start of packet, one clock |
| sfdPulse | output | 1 | Delimiter found, one clock |
| byteValid | output | 1 | New byte in `rxByte`, one clock |
| rxByte | output | 8 | Last completed byte |
| eopPulse | output | 1 | End of packet, one clock |
| noDelimiter | output | 1 | The last packet ended without a delimiter |
| byteCount | output | 16 | Bytes received since the delimiter |

## Verification
On every clock, the bound checker confirms these properties:
- each strobe is one clock wide, and no two strobes coincide;
- `rxByte` moves only with `byteValid`;
- `byteCount` only clears at a start or steps by one on a byte;
- a start follows a sampled carrier and never a half-duplex carrier with the transmitter active;
- an end follows a carrier drop that no collision excuses.

Some behaviour only the bench's frame sweeps can show. These are the exact clock positions of the delimiter, the first byte and the end relative to the carrier rise; the byte values under least-significant-bit-first packing; the skipping of a delimiter that sits inside the discarded preamble; and the collision filter keeping the byte stream intact through a carrier drop.

// File: rtl/rx_deframer_pkg.sv
package rx_deframer_pkg;

  localparam logic [7:0] SFD_CODE = 8'hD5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SKIP,
    ST_HUNT,
    ST_DATA,
    ST_DROP
  } rxState_t;

  typedef struct packed {
    logic startPkt;
    logic skipStep;
    logic huntStep;
    logic dataStep;
  } ctlStrobe_t;

endpackage

// File: rtl/rxd_datapath.sv
module rxd_datapath
  import rx_deframer_pkg::*;
#(
  parameter int SKIP_BITS = 10,
  parameter int BYTE_W    = 8,
  parameter int COUNT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxBit,
  input  ctlStrobe_t         strobe,
  output logic               skipLast,
  output logic               sfdHit,
  output logic               byteValid,
  output logic [BYTE_W-1:0]  rxByte,
  output logic [COUNT_W-1:0] byteCount
);

  localparam int SKIP_W = $clog2(SKIP_BITS + 1);
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  logic [SKIP_W-1:0] skipCnt;
  logic [BYTE_W-1:0] huntWin;
  logic [BYTE_W-1:0] huntNext;
  logic [BYTE_W-1:0] dataSh;
  logic [BYTE_W-1:0] dataNext;
  logic [BIT_W-1:0]  bitCnt;

  // Newest bit enters at the top, so after eight shifts bit 0 holds the first arrival.
  assign huntNext = {rxBit, huntWin[BYTE_W-1:1]};
  assign dataNext = {rxBit, dataSh[BYTE_W-1:1]};
  assign sfdHit   = (huntNext == BYTE_W'(SFD_CODE));
  assign skipLast = (skipCnt == SKIP_W'(SKIP_BITS - 1));

  // Preamble discard counter: the rise-edge bit counts as the first one.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      skipCnt <= '0;
    end else if (strobe.startPkt) begin
      skipCnt <= SKIP_W'(1);
    end else if (strobe.skipStep) begin
      skipCnt <= skipCnt + SKIP_W'(1);
    end
  end

  // Delimiter search window.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      huntWin <= '0;
    end else if (strobe.startPkt) begin
      huntWin <= '0;
    end else if (strobe.huntStep) begin
      huntWin <= huntNext;
    end
  end

  // Byte assembly, output byte register and byte counter.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataSh    <= '0;
      bitCnt    <= '0;
      rxByte    <= '0;
      byteValid <= 1'b0;
      byteCount <= '0;
    end else begin
      byteValid <= 1'b0;
      if (strobe.startPkt) begin
        bitCnt    <= '0;
        byteCount <= '0;
      end else if (strobe.dataStep) begin
        dataSh <= dataNext;
        bitCnt <= bitCnt + BIT_W'(1);
        if (bitCnt == LAST_BIT) begin
          rxByte    <= dataNext;
          byteValid <= 1'b1;
          if (byteCount != '1) begin
            byteCount <= byteCount + COUNT_W'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/rxd_control.sv
module rxd_control
  import rx_deframer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       carrierSense,
  input  logic       txEnable,
  input  logic       fullDuplex,
  input  logic       collision,
  input  logic       skipLast,
  input  logic       sfdHit,
  output ctlStrobe_t strobe,
  output logic       sopPulse,
  output logic       sfdPulse,
  output logic       eopPulse,
  output logic       noDelimiter
);

  rxState_t state, stateNext;
  logic     crsQ;
  logic     crsRise;
  logic     carrierHeld;
  logic     sopNext, sfdNext, eopNext, noDelimSet;

  assign crsRise     = carrierSense & ~crsQ;
  // During a half-duplex collision a missing carrier is treated as present.
  assign carrierHeld = carrierSense | (~fullDuplex & collision);

  always_comb begin
    stateNext  = state;
    strobe     = '0;
    sopNext    = 1'b0;
    sfdNext    = 1'b0;
    eopNext    = 1'b0;
    noDelimSet = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (crsRise) begin
          if (!fullDuplex && txEnable) begin
            stateNext = ST_DROP;
          end else begin
            stateNext       = ST_SKIP;
            strobe.startPkt = 1'b1;
            sopNext         = 1'b1;
          end
        end
      end
      ST_SKIP: begin
        if (!carrierHeld) begin
          stateNext  = ST_IDLE;
          eopNext    = 1'b1;
          noDelimSet = 1'b1;
        end else begin
          strobe.skipStep = 1'b1;
          if (skipLast) stateNext = ST_HUNT;
        end
      end
      ST_HUNT: begin
        if (!carrierHeld) begin
          stateNext  = ST_IDLE;
          eopNext    = 1'b1;
          noDelimSet = 1'b1;
        end else begin
          strobe.huntStep = 1'b1;
          if (sfdHit) begin
            stateNext = ST_DATA;
            sfdNext   = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (!carrierHeld) begin
          stateNext = ST_IDLE;
          eopNext   = 1'b1;
        end else begin
          strobe.dataStep = 1'b1;
        end
      end
      ST_DROP: begin
        if (!carrierSense) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      crsQ        <= 1'b1;
      sopPulse    <= 1'b0;
      sfdPulse    <= 1'b0;
      eopPulse    <= 1'b0;
      noDelimiter <= 1'b0;
    end else begin
      state    <= stateNext;
      crsQ     <= carrierSense;
      sopPulse <= sopNext;
      sfdPulse <= sfdNext;
      eopPulse <= eopNext;
      if (sopNext) begin
        noDelimiter <= 1'b0;
      end else if (noDelimSet) begin
        noDelimiter <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rx_deframer.sv
module rx_deframer
  import rx_deframer_pkg::*;
#(
  parameter int SKIP_BITS = 10,
  parameter int COUNT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               carrierSense,
  input  logic               rxBit,
  input  logic               txEnable,
  input  logic               fullDuplex,
  input  logic               collision,
  output logic               sopPulse,
  output logic               sfdPulse,
  output logic               byteValid,
  output logic [7:0]         rxByte,
  output logic               eopPulse,
  output logic               noDelimiter,
  output logic [COUNT_W-1:0] byteCount
);

  ctlStrobe_t strobe;
  logic       skipLast;
  logic       sfdHit;

  rxd_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .carrierSense (carrierSense),
    .txEnable     (txEnable),
    .fullDuplex   (fullDuplex),
    .collision    (collision),
    .skipLast     (skipLast),
    .sfdHit       (sfdHit),
    .strobe       (strobe),
    .sopPulse     (sopPulse),
    .sfdPulse     (sfdPulse),
    .eopPulse     (eopPulse),
    .noDelimiter  (noDelimiter)
  );

  rxd_datapath #(
    .SKIP_BITS (SKIP_BITS),
    .BYTE_W    (8),
    .COUNT_W   (COUNT_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .rxBit     (rxBit),
    .strobe    (strobe),
    .skipLast  (skipLast),
    .sfdHit    (sfdHit),
    .byteValid (byteValid),
    .rxByte    (rxByte),
    .byteCount (byteCount)
  );

endmodule

// File: rtl/rx_deframer_checker.sv
module rx_deframer_checker #(
  parameter int COUNT_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               carrierSense,
  input logic               txEnable,
  input logic               fullDuplex,
  input logic               collision,
  input logic               sopPulse,
  input logic               sfdPulse,
  input logic               byteValid,
  input logic [7:0]         rxByte,
  input logic               eopPulse,
  input logic               noDelimiter,
  input logic [COUNT_W-1:0] byteCount
);

  a_r2_sop_needs_carrier: assert property (@(posedge clk) disable iff (!rstN)
    sopPulse |-> $past(carrierSense));

  a_r2_sop_single: assert property (@(posedge clk) disable iff (!rstN)
    sopPulse |=> !sopPulse);

  a_r4_sfd_single: assert property (@(posedge clk) disable iff (!rstN)
    sfdPulse |=> !sfdPulse);

  a_r5_bv_single: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sopPulse, sfdPulse, byteValid, eopPulse}));

  a_r6_byte_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxByte) |-> byteValid);

  a_r7_eop_single: assert property (@(posedge clk) disable iff (!rstN)
    eopPulse |=> !eopPulse);

  a_r8_no_own_packet: assert property (@(posedge clk) disable iff (!rstN)
    sopPulse |-> $past(fullDuplex || !txEnable));

  a_r9_eop_needs_real_drop: assert property (@(posedge clk) disable iff (!rstN)
    eopPulse |-> $past(!carrierSense && (fullDuplex || !collision)));

  a_r10_nodelim_with_eop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(noDelimiter) |-> eopPulse);

  a_r11_count_steps: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(byteCount) |->
      ((byteValid && byteCount == $past(byteCount) + COUNT_W'(1)) ||
       (sopPulse && byteCount == '0)));

endmodule

bind rx_deframer rx_deframer_checker #(.COUNT_W(COUNT_W)) u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .carrierSense (carrierSense),
  .txEnable     (txEnable),
  .fullDuplex   (fullDuplex),
  .collision    (collision),
  .sopPulse     (sopPulse),
  .sfdPulse     (sfdPulse),
  .byteValid    (byteValid),
  .rxByte       (rxByte),
  .eopPulse     (eopPulse),
  .noDelimiter  (noDelimiter),
  .byteCount    (byteCount)
);

// File: tb/rx_deframer_test.sv
`timescale 1ns/1ps
module rx_deframer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        carrierSense = 1'b1;
  logic        rxBit = 1'b0;
  logic        txEnable = 1'b0;
  logic        fullDuplex = 1'b0;
  logic        collision = 1'b0;
  logic        sopPulse, sfdPulse, byteValid, eopPulse, noDelimiter;
  logic [7:0]  rxByte;
  logic [15:0] byteCount;

  always #2.5 clk = ~clk;

  rx_deframer uut (
    .clk(clk), .rstN(rstN), .carrierSense(carrierSense), .rxBit(rxBit),
    .txEnable(txEnable), .fullDuplex(fullDuplex), .collision(collision),
    .sopPulse(sopPulse), .sfdPulse(sfdPulse), .byteValid(byteValid),
    .rxByte(rxByte), .eopPulse(eopPulse), .noDelimiter(noDelimiter),
    .byteCount(byteCount)
  );

  int nChecks = 0;
  int nFail = 0;
  int bitIdx, nSop, nSfd, nBv, nEop, sfdAt, firstBvAt, eopAt;
  bit holdBad, checkBytes, zeroG;
  int seedG;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  function automatic logic [7:0] expByte(input int seed, input int i, input bit zero);
    if (zero) return 8'h00;
    return 8'((seed * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic sample();
    if (sopPulse) nSop++;
    if (sfdPulse) begin nSfd++; sfdAt = bitIdx; end
    if (byteValid) begin
      if (firstBvAt < 0) firstBvAt = bitIdx;
      if (checkBytes)
        check(rxByte == expByte(seedG, nBv, zeroG), "R5 byte value", rxByte, expByte(seedG, nBv, zeroG));
      nBv++;
    end else if (checkBytes && nBv > 0 && rxByte !== expByte(seedG, nBv - 1, zeroG)) begin
      holdBad = 1'b1;
    end
    if (eopPulse) begin nEop++; if (eopAt < 0) eopAt = bitIdx; end
    bitIdx++;
  endtask

  task automatic sendBit(input logic crs, input logic col, input logic b);
    carrierSense = crs;
    collision = col;
    rxBit = b;
    @(posedge clk);
    @(negedge clk);
    sample();
  endtask

  function automatic logic bitAt(input int k, input int preN, input int nB, input int seed, input bit zero);
    int d;
    if (k < preN) return (k % 2 == 0);
    if (k < preN + 8) return 1'((8'hD5 >> (k - preN)) & 1);
    d = k - preN - 8;
    if (d < 8 * nB) return 1'((expByte(seed, d / 8, zero) >> (d % 8)) & 1);
    return (k % 2 == 1);
  endfunction

  // Frame of preN preamble bits, delimiter, nB bytes, tail extra bits; optional collision glitch.
  task automatic frame(input int preN, input int nB, input int tail, input int seed,
                       input bit zero, input int gAt, input int gLen);
    int total;
    bitIdx = 0; nSop = 0; nSfd = 0; nBv = 0; nEop = 0;
    sfdAt = -1; firstBvAt = -1; eopAt = -1; holdBad = 1'b0;
    seedG = seed; zeroG = zero;
    total = preN + 8 + 8 * nB + tail;
    for (int k = 0; k < total; k++) begin
      bit g;
      g = (gAt >= 0) && (k >= gAt) && (k < gAt + gLen);
      sendBit(!g, g, bitAt(k, preN, nB, seed, zero));
    end
    for (int k = 0; k < 3; k++) sendBit(1'b0, 1'b0, 1'b0);
  endtask

  task automatic checkNormal(input int preN, input int nB, input int tail);
    int total;
    total = preN + 8 + 8 * nB + tail;
    check(nSop == 1, "R2 one sop", nSop, 1);
    check(nSfd == 1 && sfdAt == preN + 7, "R4 sfd position", sfdAt, preN + 7);
    check(firstBvAt == preN + 15, "R5 first byte position", firstBvAt, preN + 15);
    check(nBv == nB, "R7 byte count, partial bits dropped", nBv, nB);
    check(nEop == 1 && eopAt == total, "R7 eop position", eopAt, total);
    check(byteCount == 16'(nB), "R11 byteCount", byteCount, nB);
    check(noDelimiter == 1'b0, "R10 noDelimiter clear", noDelimiter, 0);
    check(!holdBad, "R6 rxByte held between bytes", holdBad, 0);
  endtask

  initial begin
    int savedCount;
    bit savedNd;
    checkBytes = 1'b1;
    // R1: reset state, with carrier already high
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({sopPulse, sfdPulse, byteValid, eopPulse, noDelimiter} == 5'b0, "R1 pulses in reset",
          {sopPulse, sfdPulse, byteValid, eopPulse, noDelimiter}, 0);
    check(rxByte == 8'h00 && byteCount == 16'h0, "R1 byte and count in reset", rxByte + byteCount, 0);
    rstN = 1'b1;
    bitIdx = 0; nSop = 0; nSfd = 0; nBv = 0; nEop = 0; sfdAt = -1; firstBvAt = -1; eopAt = -1;
    for (int k = 0; k < 6; k++) sendBit(1'b1, 1'b0, 1'b1);
    check(nSop == 0, "R2 carrier high at reset release gives no sop", nSop, 0);
    for (int k = 0; k < 3; k++) sendBit(1'b0, 1'b0, 1'b0);

    // Sweep: preamble length, byte count, trailing partial bits (R2 R4 R5 R6 R7 R11)
    fullDuplex = 1'b0;
    for (int p = 10; p <= 16; p += 2)
      for (int n = 1; n <= 4; n++)
        for (int t = 0; t <= 3; t++) begin
          frame(p, n, t, p * 5 + n * 3 + t, 1'b0, -1, 0);
          checkNormal(p, n, t);
        end

    // R3 / R10: delimiter inside the discarded preamble bits
    frame(2, 3, 0, 0, 1'b1, -1, 0);
    check(nSop == 1, "R3 sop issued", nSop, 1);
    check(nSfd == 0, "R3 delimiter in discarded bits ignored", nSfd, 0);
    check(nBv == 0, "R10 no bytes without delimiter", nBv, 0);
    check(nEop == 1 && eopAt == 2 + 8 + 24, "R10 eop issued", eopAt, 34);
    check(noDelimiter == 1'b1, "R10 noDelimiter set", noDelimiter, 1);
    check(byteCount == 16'h0, "R11 count cleared at sop", byteCount, 0);

    // R8: half duplex, transmitter active at carrier rise
    savedCount = byteCount;
    savedNd = noDelimiter;
    txEnable = 1'b1;
    frame(10, 2, 0, 9, 1'b0, -1, 0);
    check(nSop + nSfd + nBv + nEop == 0, "R8 own packet gives no pulses", nSop + nSfd + nBv + nEop, 0);
    check(byteCount == 16'(savedCount), "R8 count unchanged", byteCount, savedCount);
    check(noDelimiter == savedNd, "R8 noDelimiter unchanged", noDelimiter, savedNd);
    // R8: full duplex ignores txEnable
    fullDuplex = 1'b1;
    frame(12, 3, 1, 21, 1'b0, -1, 0);
    checkNormal(12, 3, 1);
    txEnable = 1'b0;

    // R9: half duplex collision glitch mid data is filtered
    fullDuplex = 1'b0;
    frame(10, 4, 0, 33, 1'b0, 10 + 8 + 5, 3);
    checkNormal(10, 4, 0);
    frame(12, 2, 2, 44, 1'b0, 12 + 2, 2);
    check(nSfd == 0 || sfdAt == 19, "R9 glitch in hunt filtered", sfdAt, 19);
    checkNormal(12, 2, 2);

    // R9: full duplex, collision ignored, carrier drop ends packet
    fullDuplex = 1'b1;
    checkBytes = 1'b0;
    frame(10, 4, 0, 55, 1'b0, 10 + 8 + 5, 3);
    check(eopAt == 23, "R9 full duplex drop ends packet", eopAt, 23);
    check(nSop == 2, "R9 carrier return starts new packet", nSop, 2);
    checkBytes = 1'b1;

    // Recovery frame after the interrupted one
    frame(10, 1, 0, 66, 1'b0, -1, 0);
    checkNormal(10, 1, 0);

    finishRun();
  end

endmodule